// File: doc/BRIEF.md
# Ring-Buffer Receive DMA Engine

This engine takes a byte stream carrying an end-of-frame marker and writes it into a ring of equal-sized memory buffers. Each buffer has a slot, its descriptor, at a fixed stride from a descriptor base. The descriptors form a ring in index order, so the one after the last index is index 0.

A current-descriptor index selects the buffer being filled. A buffer is closed when it is full or when the last byte of a frame lands in it. The engine then writes a status word back into that buffer's descriptor and moves the current index on by one. A frame longer than one buffer flows on into the next descriptor.

An end-descriptor index, which the host may rewrite at any moment, marks the first descriptor the engine may not enter. The host hands buffers back by moving it forward. In multi-frame mode the engine keeps running across frames. It counts frame ends the host has not yet acknowledged in a 4-bit counter. If that counter would pass 15, reception stops and an error interrupt is raised.

Top module: `rxdma_chain`

## Requirements
- R1: After reset, the status register reads 0, `in_ready`, `mem_valid`, `irq_frame`, `irq_err` and `irq_exh` are low, and both indices are 0.
- R2: Byte k of the buffer at index i is written with `mem_kind`=0 to address BUF_BASE + i*BUF_LEN + k, with the byte in `mem_wdata[7:0]`. A write stays stable until `mem_ready` is high. `in_ready` is low while a write is pending.
- R3: On closing a buffer, a write with `mem_kind`=1 goes to DESC_BASE + i*DESC_STRIDE. Its data has bit 15 = end-of-frame and the low bits = bytes stored. A frame that spans several buffers sets bit 15 only in the buffer holding its last byte.
- R4: Register map. Writing address 0 sets control: bit0 start, bit1 multi-frame, bit2 error-interrupt enable, bit3 exhaustion-interrupt enable. Reading address 0 returns status: bit0 multi-frame, bit1 enable, bit2 overflow flag, bit3 exhaustion flag, bits 7:4 frame-end count. Address 1 is the current index and address 2 is the end index. Writing bit0 of address 3 acknowledges one frame end.
- R5: In multi-frame mode, the enable bit stays set after a frame ends. The current index advances by one per closed buffer and wraps from DESC_N-1 to 0.
- R6: With multi-frame clear, the enable bit clears once a frame's descriptor has been written.
- R7: Each frame end adds one to the frame-end count, and `irq_frame` is high while the count is nonzero. An acknowledge subtracts one, and at 0 it leaves the count at 0.
- R8: A frame end that finds the count at 15 clears the count, clears the enable bit and sets the overflow flag. `irq_err` then follows that flag AND the error-interrupt enable.
- R9: If advancing makes the current index equal the end index, the engine clears the enable bit and sets the exhaustion flag. `irq_exh` follows that flag AND its enable. No further byte is accepted, even mid-frame.
- R10: The end index may be written at any time. A write to the current index is ignored while enabled. A start clears both flags, and the engine resumes at the current index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Byte is the last of its frame |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_kind | output | 1 | 0 = buffer byte, 1 = descriptor status |
| mem_addr | output | AW | Write address |
| mem_wdata | output | 16 | Write data |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| irq_frame | output | 1 | Unserviced frame ends pending |
| irq_err | output | 1 | Counter overflow interrupt |
| irq_exh | output | 1 | Buffers exhausted interrupt |

## Verification
The bench drives frames that fit in one buffer, frames that end exactly on a buffer boundary, and frames that span two buffers. A design that marks end-of-frame in every descriptor, or miscounts the boundary byte, shows up as a wrong status word or a wrong byte address.

A frame that runs into the end index is cut mid-frame. A design that overwrites unreleased buffers would keep accepting its fifth byte. The host then releases buffers and restarts, which checks that the engine resumes at the index it stopped on.

The frame-end count is driven to 15 and then one more frame is sent. A counter that wraps instead of terminating would show 0 with the engine still enabled, and the error interrupt would stay low. Acknowledging at 0 catches a counter that underflows to 15. A start without multi-frame catches an engine that stays enabled after one frame.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_DESC  = 2'd2,
    ST_DWAIT = 2'd3
  } rx_state_e;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_CUR  = 2'd1;
  localparam logic [1:0] RA_END  = 2'd2;
  localparam logic [1:0] RA_ACK  = 2'd3;

  localparam int CTL_GO    = 0;
  localparam int CTL_MULTI = 1;
  localparam int CTL_ERRIE = 2;
  localparam int CTL_EXHIE = 3;
endpackage

// File: rtl/rxdma_fecnt.sv
module rxdma_fecnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         full
);
  logic empty;

  assign full  = (cnt == {W{1'b1}});
  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && !dec && !full) begin
      cnt <= cnt + 1'b1;
    end else if (dec && !inc && !empty) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rxdma_ring.sv
module rxdma_ring #(
  parameter int DESC_N = 8,
  parameter int IW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cur_we,
  input  logic          end_we,
  input  logic [IW-1:0] wr_idx,
  input  logic          adv,
  output logic [IW-1:0] cur_idx,
  output logic [IW-1:0] end_idx,
  output logic          nxt_hits_end
);
  localparam logic [IW-1:0] LAST_IDX = IW'(DESC_N - 1);

  logic [IW-1:0] nxt_idx;

  assign nxt_idx      = (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;
  assign nxt_hits_end = (nxt_idx == end_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx <= '0;
    end else if (adv) begin
      cur_idx <= nxt_idx;
    end else if (cur_we) begin
      cur_idx <= wr_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      end_idx <= '0;
    end else if (end_we) begin
      end_idx <= wr_idx;
    end
  end
endmodule

// File: rtl/rxdma_wport.sv
module rxdma_wport #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ld_kind,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic          mem_kind,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_kind  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (load) begin
      mem_valid <= 1'b1;
      mem_kind  <= ld_kind;
      mem_addr  <= ld_addr;
      mem_wdata <= ld_data;
    end else if (mem_ready) begin
      mem_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rxdma_chain.sv
module rxdma_chain
  import rxdma_pkg::*;
#(
  parameter int          DESC_N      = 8,
  parameter int          BUF_LEN     = 4,
  parameter int          AW          = 16,
  parameter int          FC_W        = 4,
  parameter logic [15:0] BUF_BASE    = 16'h1000,
  parameter logic [15:0] DESC_BASE   = 16'h0100,
  parameter int          DESC_STRIDE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_kind,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq_frame,
  output logic          irq_err,
  output logic          irq_exh
);
  localparam int IW = (DESC_N > 1) ? $clog2(DESC_N) : 1;
  localparam int CW = $clog2(BUF_LEN + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(BUF_LEN - 1);

  rx_state_e     state;
  logic [CW-1:0] byte_cnt;
  logic          eof_q;
  logic          de_q, multi_q, err_ie_q, exh_ie_q;
  logic          err_flag_q, exh_flag_q;

  logic [IW-1:0] cur_idx, end_idx;
  logic          nxt_hits_end;
  logic [FC_W-1:0] fcnt;
  logic          fc_full;

  // Host decode
  logic ctrl_we, go, cur_we, end_we, ack;
  assign ctrl_we = reg_we && (reg_addr == RA_CTRL);
  assign go      = ctrl_we && reg_wdata[CTL_GO];
  assign cur_we  = reg_we && (reg_addr == RA_CUR) && !de_q;
  assign end_we  = reg_we && (reg_addr == RA_END);
  assign ack     = reg_we && (reg_addr == RA_ACK) && reg_wdata[0];

  // Stream side
  logic accept, close_buf, desc_launch, desc_done, frame_end, ovf, stop;
  assign in_ready    = de_q && (state == ST_DATA) && !mem_valid;
  assign accept      = in_valid && in_ready;
  assign close_buf   = accept && (in_last || (byte_cnt == FULL_CNT));
  assign desc_launch = (state == ST_DESC) && !mem_valid;
  assign desc_done   = (state == ST_DWAIT) && mem_valid && mem_ready;
  assign frame_end   = desc_done && eof_q;
  assign ovf         = frame_end && fc_full;
  assign stop        = ovf || nxt_hits_end || (eof_q && !multi_q);

  // Address and data for the write port
  logic [AW-1:0] data_addr, desc_addr, ld_addr;
  logic [15:0]   desc_word, ld_data;
  assign data_addr = AW'(BUF_BASE) + AW'(cur_idx) * AW'(BUF_LEN) + AW'(byte_cnt);
  assign desc_addr = AW'(DESC_BASE) + AW'(cur_idx) * AW'(DESC_STRIDE);
  assign desc_word = {eof_q, {(15 - CW){1'b0}}, byte_cnt};
  assign ld_addr   = desc_launch ? desc_addr : data_addr;
  assign ld_data   = desc_launch ? desc_word : {8'h00, in_data};

  rxdma_wport #(.AW(AW), .DW(16)) u_wport (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept || desc_launch),
    .ld_kind   (desc_launch),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_kind  (mem_kind),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  rxdma_ring #(.DESC_N(DESC_N), .IW(IW)) u_ring (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_we       (cur_we),
    .end_we       (end_we),
    .wr_idx       (reg_wdata[IW-1:0]),
    .adv          (desc_done),
    .cur_idx      (cur_idx),
    .end_idx      (end_idx),
    .nxt_hits_end (nxt_hits_end)
  );

  rxdma_fecnt #(.W(FC_W)) u_fecnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (frame_end && !fc_full),
    .dec   (ack),
    .clr   (ovf),
    .cnt   (fcnt),
    .full  (fc_full)
  );

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      byte_cnt <= '0;
      eof_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          byte_cnt <= '0;
          if (de_q) state <= ST_DATA;
        end
        ST_DATA: begin
          if (accept) begin
            byte_cnt <= byte_cnt + 1'b1;
            if (close_buf) begin
              eof_q <= in_last;
              state <= ST_DESC;
            end
          end
        end
        ST_DESC: begin
          if (desc_launch) state <= ST_DWAIT;
        end
        ST_DWAIT: begin
          if (desc_done) begin
            byte_cnt <= '0;
            state    <= stop ? ST_IDLE : ST_DATA;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Control and flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_q       <= 1'b0;
      multi_q    <= 1'b0;
      err_ie_q   <= 1'b0;
      exh_ie_q   <= 1'b0;
      err_flag_q <= 1'b0;
      exh_flag_q <= 1'b0;
    end else begin
      if (ctrl_we) begin
        multi_q  <= reg_wdata[CTL_MULTI];
        err_ie_q <= reg_wdata[CTL_ERRIE];
        exh_ie_q <= reg_wdata[CTL_EXHIE];
      end
      if (go) begin
        de_q       <= 1'b1;
        err_flag_q <= 1'b0;
        exh_flag_q <= 1'b0;
      end else if (desc_done) begin
        if (stop)         de_q       <= 1'b0;
        if (ovf)          err_flag_q <= 1'b1;
        if (nxt_hits_end) exh_flag_q <= 1'b1;
      end
    end
  end

  // Host read
  always_comb begin
    unique case (reg_addr)
      RA_CTRL: reg_rdata = {fcnt, exh_flag_q, err_flag_q, de_q, multi_q};
      RA_CUR:  reg_rdata = 8'(cur_idx);
      RA_END:  reg_rdata = 8'(end_idx);
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq_frame = (fcnt != '0);
  assign irq_err   = err_flag_q && err_ie_q;
  assign irq_exh   = exh_flag_q && exh_ie_q;
endmodule

// File: rtl/rxdma_chain_chk.sv
module rxdma_chain_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_kind,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic          de,
  input logic [3:0]    fcnt,
  input logic          err_flag,
  input logic          exh_flag
);
  // R2: a stalled write keeps its request, address, data and kind
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_wdata) && $stable(mem_kind)));

  // R9: no byte is accepted while the engine is disabled
  p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> !in_ready);

  // R9: exhaustion always leaves the engine disabled
  p_exh_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exh_flag) |-> !de);

  // R8: overflow clears the count and disables the engine
  p_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (fcnt == 4'h0 && !de));

  // R8: a drop from 15 straight to 0 only ever comes with the overflow flag
  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fcnt) == 4'hF && fcnt == 4'h0) |-> err_flag);

  // R7: an acknowledge never wraps the count from 0 to 15
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fcnt) == 4'h0) |-> (fcnt != 4'hF));
endmodule

bind rxdma_chain rxdma_chain_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_kind  (mem_kind),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .de        (de_q),
  .fcnt      (fcnt),
  .err_flag  (err_flag_q),
  .exh_flag  (exh_flag_q)
);

// File: tb/rxdma_chain_bench.sv
module rxdma_chain_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // {len, cda after, fcnt after, spare, descriptor word}
  localparam logic [47:0] VEC [0:NV-1] = '{
    {8'd3, 8'd1, 8'd1, 8'd0, 16'h8003},
    {8'd4, 8'd2, 8'd2, 8'd0, 16'h8004},
    {8'd6, 8'd4, 8'd3, 8'd0, 16'h8002},
    {8'd1, 8'd5, 8'd4, 8'd0, 16'h8001},
    {8'd8, 8'd7, 8'd5, 8'd0, 16'h8004}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready;
  logic mem_valid, mem_kind;
  logic mem_ready = 1'b1;
  logic [15:0] mem_addr, mem_wdata;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic irq_frame, irq_err, irq_exh;

  int checks = 0;
  int failures = 0;
  logic [7:0] bmem [0:31];
  logic [15:0] last_desc = 16'h0000;
  int cda_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdma_chain u_rxdma_chain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_kind(mem_kind), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_frame(irq_frame),
    .irq_err(irq_err), .irq_exh(irq_exh)
  );

  // Memory model
  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_kind) last_desc <= mem_wdata;
      else bmem[mem_addr[4:0]] <= mem_wdata[7:0];
    end
  end

  // Back-pressure: memory stalls one cycle in three
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      mem_ready = (k % 3) != 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed, output int sent);
    sent = 0;
    for (int k = 0; k < len; k++) begin
      int waits = 0;
      @(negedge clk);
      in_valid = 1'b1; in_data = seed + 8'(k); in_last = (k == len - 1);
      while (!in_ready && waits < 30) begin
        @(negedge clk);
        waits++;
      end
      if (!in_ready) begin
        in_valid = 1'b0; in_last = 1'b0;
        return;
      end
      @(negedge clk);
      sent++;
      in_valid = 1'b0; in_last = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int sent;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(2'd0, rd);
    chk("R1 status", rd, 8'h00);
    chk("R1 outputs", {in_ready, mem_valid, irq_frame, irq_err, irq_exh}, 5'b0);
    reg_read(2'd1, rd);
    chk("R1 cur index", rd, 8'h00);

    // Start multi-frame, both interrupt enables
    reg_write(2'd2, 8'd0);
    reg_write(2'd0, 8'h0F);
    reg_read(2'd0, rd);
    chk("R4 status after start", rd, 8'h03);

    // Vector table: single, boundary and spanning frames (R2 R3 R5 R7)
    for (int i = 0; i < NV; i++) begin
      int len, last_i;
      logic [7:0] seed;
      len  = int'(VEC[i][47:40]);
      seed = 8'(8'h10 * (i + 1));
      send_frame(len, seed, sent);
      settle();
      chk("R2 bytes accepted", sent, len);
      chk("R3 descriptor word", last_desc, VEC[i][15:0]);
      chk("R2 first byte placement", bmem[cda_m * 4], seed);
      last_i = ((int'(VEC[i][39:32]) + 7) % 8) * 4 + ((len - 1) % 4);
      chk("R2 last byte placement", bmem[last_i], seed + 8'(len - 1));
      reg_read(2'd1, rd);
      chk("R5 cur index advance", rd, VEC[i][39:32]);
      reg_read(2'd0, rd);
      chk("R7 frame count", rd[7:4], VEC[i][27:24]);
      chk("R5 still enabled", rd[1], 1'b1);
      cda_m = int'(VEC[i][39:32]);
    end
    chk("R7 irq_frame pending", irq_frame, 1'b1);

    // R10 current index write ignored while enabled
    reg_write(2'd1, 8'd2);
    reg_read(2'd1, rd);
    chk("R10 cur write ignored", rd, 8'd7);

    // R9 exhaustion mid-frame: desc7 fills, next is end index 0
    send_frame(5, 8'hA0, sent);
    settle();
    chk("R9 bytes before stop", sent, 4);
    chk("R3 no eof on partial buffer", last_desc, 16'h0004);
    reg_read(2'd0, rd);
    chk("R9 status disabled+exhausted", rd, 8'h59);
    chk("R9 irq_exh", irq_exh, 1'b1);
    chk("R9 in_ready low", in_ready, 1'b0);
    reg_read(2'd1, rd);
    chk("R5 wrap to 0", rd, 8'd0);

    // R10 release buffers and restart
    reg_write(2'd2, 8'd3);
    reg_write(2'd0, 8'h0F);
    reg_read(2'd0, rd);
    chk("R10 start clears flags", rd, 8'h53);
    send_frame(1, 8'hA4, sent);
    settle();
    chk("R3 tail of cut frame", last_desc, 16'h8001);
    chk("R2 resumed placement", bmem[0], 8'hA4);
    cda_m = 1;

    // R7 acknowledge
    reg_write(2'd3, 8'h01);
    reg_write(2'd3, 8'h01);
    reg_read(2'd0, rd);
    chk("R7 ack decrement", rd[7:4], 4'd4);

    // Fill count to 15 while moving the end index (R10)
    for (int f = 0; f < 11; f++) begin
      reg_write(2'd2, 8'((cda_m + 4) % 8));
      send_frame(1, 8'(f), sent);
      settle();
      cda_m = (cda_m + 1) % 8;
    end
    reg_read(2'd0, rd);
    chk("R7 count at 15", rd, 8'hF3);
    reg_read(2'd1, rd);
    chk("R10 end moves keep running", rd, 8'(cda_m));

    // R8 overflow
    reg_write(2'd2, 8'((cda_m + 4) % 8));
    send_frame(1, 8'h77, sent);
    settle();
    reg_read(2'd0, rd);
    chk("R8 overflow status", rd, 8'h05);
    chk("R8 irq_err", irq_err, 1'b1);
    chk("R8 irq_frame cleared", irq_frame, 1'b0);
    chk("R8 in_ready low", in_ready, 1'b0);
    cda_m = (cda_m + 1) % 8;

    // R7 acknowledge at zero saturates
    reg_write(2'd3, 8'h01);
    reg_read(2'd0, rd);
    chk("R7 ack at zero", rd[7:4], 4'd0);

    // R6 single-frame mode
    reg_write(2'd2, 8'((cda_m + 4) % 8));
    reg_write(2'd0, 8'h0D);
    send_frame(2, 8'h30, sent);
    settle();
    reg_read(2'd0, rd);
    chk("R6 disabled after frame", rd, 8'h10);
    chk("R6 descriptor", last_desc, 16'h8002);
    chk("R6 in_ready low", in_ready, 1'b0);
    chk("R8 irq_err cleared by start", irq_err, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule